// File: doc/BRIEF.md
# Register-Mode Memory-to-Stream DMA Channel

This block is one transmit channel of a DMA engine that moves a contiguous region of memory onto a streaming output. Software programs it through a four-entry register file. It first writes the start byte address, then the byte count. The write of a nonzero count is the trigger. The channel reads the region over a simple burst read port, in order, one word per beat. It forwards each word on an AXI4-Stream master with byte enables, and flags the final beat with TLAST.

Memory reads are split into bursts. Each burst is capped by a parameterised beat limit and never runs past a 4 KB page. When a transfer finishes, the channel raises a completion flag. A start from a misaligned address raises an error flag instead and moves no data. Each flag is cleared by writing one to it, and each drives the interrupt line through its own enable bit. A soft-reset bit in the control entry abandons a running transfer. The channel first drains the read burst already in flight, then returns to idle.

Register map by word index: 0 = control, 1 = status, 2 = source address, 3 = byte length.

Top module: `m2s_dma_chan`

## Requirements
- R1: After reset, status reads 0x1 (idle set, both flags clear), the length entry reads 0, and irq, rd_req_valid and m_tvalid are low.
- R2: Writing a nonzero length while idle, with an aligned source address, starts a transfer. Writing zero starts nothing.
- R3: Only the low LEN_W (default 14) bits of a length write are kept. Writing 0x4000 stores 0 and starts nothing. Writing 0x4008 moves 8 bytes.
- R4: The stream carries the memory words in ascending address order, one word per beat. There are ceil(len/4) beats, and TLAST is high on the final beat only. A 256-byte transfer gives 64 beats.
- R5: Every beat except the last has m_tkeep = 4'b1111. On the last beat, len mod 4 = 1, 2, 3, 0 gives m_tkeep = 4'b0001, 4'b0011, 4'b0111, 4'b1111.
- R6: A start whose source address has a nonzero value in bits [1:0] sets the error flag (status bit 2). It issues no read request and emits no beat, and the channel stays idle.
- R7: Every read request asks for 1 to MAX_BURST (default 16) beats, never crosses a 4 KB address boundary, and is held stable until accepted. Only one burst is outstanding at a time.
- R8: A write to the length entry while a transfer runs is ignored. The running transfer and the stored length are unchanged.
- R9: Status bit 0 is idle, bit 1 is completion, and bit 2 is error. Completion is set when the final beat is accepted. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: irq = (completion AND control bit 0) OR (error AND control bit 1).
- R11: Writing control bit 2 = 1 clears both enables, both flags, the source address and the length. A running transfer then drains its outstanding burst without emitting beats and goes idle without TLAST or completion. A later transfer works normally.
- R12: When m_tready is low, the current beat waits. No beat is lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 2 | Register index for the write |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_idx | input | 2 | Register index for the read |
| cfg_rd_data | output | 32 | Read data for cfg_rd_idx (combinational) |
| irq | output | 1 | Interrupt line |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Burst read request accepted |
| rd_req_addr | output | ADDR_W | Burst start byte address |
| rd_req_beats | output | BURST_W | Burst length in beats |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_ready | output | 1 | Read data beat accepted |
| rd_rsp_data | input | DATA_W | Read data beat |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/8 | Stream byte enables |
| m_tlast | output | 1 | Final beat of the transfer |

## Verification
Some properties are checked on every cycle. Every read request must be sized within the burst cap and stay inside its 4 KB page. It must be word-aligned and held steady while stalled, and only one burst may be in flight. Stream byte enables must be contiguous from lane 0 and full on every beat except the last.

Other behaviours only the bench scenarios can show. These are: data order and beat count, the exact partial enables for each remainder, and the flag, enable and W1C interplay on the interrupt line. They also include ignoring of length writes while busy or truncated to zero, the misaligned-start error, and the soft-reset drain followed by a clean restart.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_REQ    = 2'd1,
    ENG_STREAM = 2'd2
  } eng_state_e;

  // register file word indices
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_SRC  = 2'd2;
  localparam logic [1:0] IDX_LEN  = 2'd3;

  // control bits
  localparam int CTRL_DONE_EN = 0;
  localparam int CTRL_ERR_EN  = 1;
  localparam int CTRL_SRST    = 2;

  // status bits
  localparam int STAT_IDLE = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;

endpackage

// File: rtl/m2s_rst_sync.sv
module m2s_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/m2s_cfg_regs.sv
module m2s_cfg_regs
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int AB     = 2,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_idx,
  output logic [REG_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              done_evt,
  output logic              start,
  output logic [ADDR_W-1:0] start_src,
  output logic [LEN_W-1:0]  start_len,
  output logic              soft_rst,
  output logic              irq
);

  logic              done_en_q, done_en_d;
  logic              err_en_q, err_en_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic             wr_ctrl, wr_stat, wr_src, wr_len;
  logic [LEN_W-1:0] len_in;
  logic             go, misaligned, err_evt;
  logic             unused_wr;

  assign unused_wr = ^wr_data;

  // decode of the write port
  always_comb begin
    wr_ctrl    = wr_en && (wr_idx == IDX_CTRL);
    wr_stat    = wr_en && (wr_idx == IDX_STAT);
    wr_src     = wr_en && (wr_idx == IDX_SRC);
    wr_len     = wr_en && (wr_idx == IDX_LEN) && !busy;
    len_in     = wr_data[LEN_W-1:0];
    soft_rst   = wr_ctrl && wr_data[CTRL_SRST];
    go         = wr_len && (len_in != '0);
    misaligned = (src_q[AB-1:0] != '0);
    start      = go && !misaligned;
    err_evt    = go && misaligned;
  end

  assign start_src = src_q;
  assign start_len = len_in;

  // next-state
  always_comb begin
    done_en_d = done_en_q;
    err_en_d  = err_en_q;
    src_d     = src_q;
    len_d     = len_q;
    if (wr_ctrl) begin
      done_en_d = wr_data[CTRL_DONE_EN];
      err_en_d  = wr_data[CTRL_ERR_EN];
    end
    if (wr_src) src_d = wr_data[ADDR_W-1:0];
    if (wr_len) len_d = len_in;
    done_d = (done_q && !(wr_stat && wr_data[STAT_DONE])) || done_evt;
    err_d  = (err_q  && !(wr_stat && wr_data[STAT_ERR]))  || err_evt;
    if (soft_rst) begin
      done_en_d = 1'b0;
      err_en_d  = 1'b0;
      done_d    = 1'b0;
      err_d     = 1'b0;
      src_d     = '0;
      len_d     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_en_q <= 1'b0;
      err_en_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      src_q     <= '0;
      len_q     <= '0;
    end else begin
      done_en_q <= done_en_d;
      err_en_q  <= err_en_d;
      done_q    <= done_d;
      err_q     <= err_d;
      if (wr_src || soft_rst) src_q <= src_d;
      if (wr_len || soft_rst) len_q <= len_d;
    end
  end

  assign irq = (done_q && done_en_q) || (err_q && err_en_q);

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_CTRL: begin
        rd_data[CTRL_DONE_EN] = done_en_q;
        rd_data[CTRL_ERR_EN]  = err_en_q;
      end
      IDX_STAT: begin
        rd_data[STAT_IDLE] = !busy;
        rd_data[STAT_DONE] = done_q;
        rd_data[STAT_ERR]  = err_q;
      end
      IDX_SRC: rd_data[ADDR_W-1:0] = src_q;
      default: rd_data[LEN_W-1:0]  = len_q;
    endcase
  end

endmodule

// File: rtl/m2s_burst_plan.sv
module m2s_burst_plan #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 13,
  parameter int BURST_W    = 5,
  parameter int MAX_BURST  = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int AB         = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BEAT_W-1:0]  beats_left,
  output logic [BURST_W-1:0] burst_beats
);

  localparam int PAGE_AW    = $clog2(PAGE_BYTES);
  localparam int PAGE_BEATS = PAGE_BYTES >> AB;

  logic [31:0] to_page, left_w, pick;
  logic        unused_addr;

  assign unused_addr = ^{addr[ADDR_W-1:PAGE_AW], addr[AB-1:0]};

  // smallest of: cap, beats to the page end, beats still owed
  always_comb begin
    to_page = 32'(PAGE_BEATS) - 32'(addr[PAGE_AW-1:AB]);
    left_w  = 32'(beats_left);
    pick    = 32'(MAX_BURST);
    if (to_page < pick) pick = to_page;
    if (left_w < pick)  pick = left_w;
    burst_beats = pick[BURST_W-1:0];
  end

endmodule

// File: rtl/m2s_read_engine.sv
module m2s_read_engine
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 14,
  parameter int MAX_BURST  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int KEEP_W    = DATA_W / 8,
  localparam int AB        = $clog2(KEEP_W),
  localparam int BEAT_W    = LEN_W - AB + 1,
  localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_src,
  input  logic [LEN_W-1:0]   start_len,
  input  logic               soft_rst,
  output logic               busy,
  output logic               done_evt,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [BURST_W-1:0] rd_req_beats,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [DATA_W-1:0]  m_tdata,
  output logic [KEEP_W-1:0]  m_tkeep,
  output logic               m_tlast
);

  eng_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [KEEP_W-1:0] keep_last_q, keep_last_d;
  logic              abort_q, abort_d;
  logic              addr_en;

  logic [BURST_W-1:0] plan_beats;
  logic [LEN_W:0]     ceil_w;
  logic [AB-1:0]      rem;
  logic [KEEP_W-1:0]  start_keep;
  logic               streaming, is_final, beat_fire;
  logic               unused_ceil;

  m2s_burst_plan #(
    .ADDR_W    (ADDR_W),
    .BEAT_W    (BEAT_W),
    .BURST_W   (BURST_W),
    .MAX_BURST (MAX_BURST),
    .PAGE_BYTES(PAGE_BYTES),
    .AB        (AB)
  ) u_plan (
    .addr       (addr_q),
    .beats_left (beats_q),
    .burst_beats(plan_beats)
  );

  // beat count and final-beat byte enables from the programmed length
  assign ceil_w      = ({1'b0, start_len} + (LEN_W+1)'(KEEP_W - 1)) >> AB;
  assign unused_ceil = ^ceil_w;
  assign rem         = start_len[AB-1:0];

  for (genvar g = 0; g < KEEP_W; g++) begin : g_lane
    assign start_keep[g] = (rem == '0) || (AB'(g) < rem);
  end

  // outputs
  always_comb begin
    busy         = (state_q != ENG_IDLE);
    streaming    = (state_q == ENG_STREAM);
    rd_req_valid = (state_q == ENG_REQ);
    rd_req_addr  = addr_q;
    rd_req_beats = plan_beats;
    is_final     = (beats_q == BEAT_W'(1));
    m_tvalid     = streaming && !abort_q && rd_rsp_valid;
    rd_rsp_ready = streaming && (abort_q || m_tready);
    m_tdata      = rd_rsp_data;
    m_tkeep      = is_final ? keep_last_q : '1;
    m_tlast      = m_tvalid && is_final;
    beat_fire    = streaming && rd_rsp_valid && rd_rsp_ready;
    done_evt     = beat_fire && is_final && !abort_q;
  end

  // next-state
  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    beats_d     = beats_q;
    burst_d     = burst_q;
    keep_last_d = keep_last_q;
    abort_d     = abort_q || (soft_rst && busy);
    addr_en     = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        abort_d = 1'b0;
        if (start) begin
          addr_d      = start_src;
          addr_en     = 1'b1;
          beats_d     = ceil_w[BEAT_W-1:0];
          keep_last_d = start_keep;
          state_d     = ENG_REQ;
        end
      end
      ENG_REQ: begin
        if (rd_req_ready) begin
          burst_d = plan_beats;
          addr_d  = addr_q + (ADDR_W'(plan_beats) << AB);
          addr_en = 1'b1;
          state_d = ENG_STREAM;
        end
      end
      ENG_STREAM: begin
        if (beat_fire) begin
          beats_d = beats_q - BEAT_W'(1);
          burst_d = burst_q - BURST_W'(1);
          if (is_final) begin
            state_d = ENG_IDLE;
            abort_d = 1'b0;
          end else if (burst_q == BURST_W'(1)) begin
            if (abort_q) begin
              state_d = ENG_IDLE;
              abort_d = 1'b0;
            end else begin
              state_d = ENG_REQ;
            end
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ENG_IDLE;
      addr_q      <= '0;
      beats_q     <= '0;
      burst_q     <= '0;
      keep_last_q <= '0;
      abort_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      beats_q     <= beats_d;
      burst_q     <= burst_d;
      keep_last_q <= keep_last_d;
      abort_q     <= abort_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/m2s_dma_chan.sv
module m2s_dma_chan
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 14,
  parameter int MAX_BURST  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int KEEP_W    = DATA_W / 8,
  localparam int AB        = $clog2(KEEP_W),
  localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_wr_idx,
  input  logic [31:0]        cfg_wr_data,
  input  logic [1:0]         cfg_rd_idx,
  output logic [31:0]        cfg_rd_data,
  output logic               irq,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [BURST_W-1:0] rd_req_beats,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [DATA_W-1:0]  m_tdata,
  output logic [KEEP_W-1:0]  m_tkeep,
  output logic               m_tlast
);

  logic              rst_sync_n;
  logic              busy, done_evt, start, soft_rst;
  logic [ADDR_W-1:0] start_src;
  logic [LEN_W-1:0]  start_len;

  m2s_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  m2s_cfg_regs #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .AB    (AB),
    .REG_W (32)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_wr_en),
    .wr_idx   (cfg_wr_idx),
    .wr_data  (cfg_wr_data),
    .rd_idx   (cfg_rd_idx),
    .rd_data  (cfg_rd_data),
    .busy     (busy),
    .done_evt (done_evt),
    .start    (start),
    .start_src(start_src),
    .start_len(start_len),
    .soft_rst (soft_rst),
    .irq      (irq)
  );

  m2s_read_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .MAX_BURST (MAX_BURST),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .start_src   (start_src),
    .start_len   (start_len),
    .soft_rst    (soft_rst),
    .busy        (busy),
    .done_evt    (done_evt),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_req_beats(rd_req_beats),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data (rd_rsp_data),
    .m_tvalid    (m_tvalid),
    .m_tready    (m_tready),
    .m_tdata     (m_tdata),
    .m_tkeep     (m_tkeep),
    .m_tlast     (m_tlast)
  );

endmodule

// File: rtl/m2s_dma_chan_chk.sv
module m2s_dma_chan_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_BURST  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int KEEP_W    = DATA_W / 8,
  localparam int AB        = $clog2(KEEP_W),
  localparam int BURST_W   = $clog2(MAX_BURST + 1),
  localparam int PAGE_AW   = $clog2(PAGE_BYTES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic [BURST_W-1:0] rd_req_beats,
  input logic               m_tvalid,
  input logic [KEEP_W-1:0]  m_tkeep,
  input logic               m_tlast
);

  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_beats != '0) && (int'(rd_req_beats) <= MAX_BURST)); // R7

  AST_BURST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (int'(rd_req_addr[PAGE_AW-1:0]) + (int'(rd_req_beats) << AB)) <= PAGE_BYTES); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats)); // R7

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid); // R7

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[AB-1:0] == '0)); // R6

  AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tkeep[0] && ((m_tkeep & (m_tkeep + 1'b1)) == '0)); // R5

  AST_KEEP_FULL_MID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> (&m_tkeep)); // R5

endmodule

bind m2s_dma_chan m2s_dma_chan_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MAX_BURST (MAX_BURST),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_req_beats(rd_req_beats),
  .m_tvalid    (m_tvalid),
  .m_tkeep     (m_tkeep),
  .m_tlast     (m_tlast)
);

// File: tb/m2s_dma_chan_tb.sv
`timescale 1ns/1ps
module m2s_dma_chan_tb;

  localparam int MAX_BURST = 16;
  localparam int BURST_W   = $clog2(MAX_BURST + 1);

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  keep;
    logic        last;
  } beat_t;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_wr_en;
  logic [1:0]         cfg_wr_idx;
  logic [31:0]        cfg_wr_data;
  logic [1:0]         cfg_rd_idx;
  logic [31:0]        cfg_rd_data;
  logic               irq;
  logic               rd_req_valid, rd_req_ready;
  logic [31:0]        rd_req_addr;
  logic [BURST_W-1:0] rd_req_beats;
  logic               rd_rsp_valid, rd_rsp_ready;
  logic [31:0]        rd_rsp_data;
  logic               m_tvalid, m_tready, m_tlast;
  logic [31:0]        m_tdata;
  logic [3:0]         m_tkeep;

  m2s_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data), .irq(irq),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast)
  );

  always #2.5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    rdy_mode = 0;
  int    beats_seen = 0;
  int    lasts_seen = 0;
  int    n_req = 0;
  int    burst_left = 0;
  logic [31:0] burst_addr = '0;
  logic [31:0] exp_next_addr = '0;
  beat_t exp_q[$];
  int    req_log[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected beats for a transfer
  task automatic push_expect(logic [31:0] src, int nbytes);
    int nb = (nbytes + 3) / 4;
    for (int i = 0; i < nb; i++) begin
      beat_t b;
      b.data = mem_word(src + 32'(4 * i));
      b.keep = (i == nb - 1 && (nbytes % 4) != 0) ? 4'((1 << (nbytes % 4)) - 1) : 4'hF;
      b.last = (i == nb - 1);
      exp_q.push_back(b);
    end
    exp_next_addr = src;
  endtask

  task automatic cfg_write(logic [1:0] idx, logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    cfg_rd_idx = idx;
    #1;
    data = cfg_rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      cfg_read(2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic start_xfer(logic [31:0] src, logic [31:0] len_wr, int nbytes);
    req_log.delete();
    push_expect(src, nbytes);
    cfg_write(2'd2, src);
    cfg_write(2'd3, len_wr);
  endtask

  // memory model: accepts bursts, returns words in order
  initial begin
    bit fired;
    fired = 1'b0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    forever begin
      @(negedge clk);
      rd_req_ready = (cyc % 3) != 0;
      if (fired) rd_rsp_valid = 1'b0;
      if (!rd_rsp_valid && burst_left > 0 && (cyc % 5) != 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem_word(burst_addr);
      end
      #1;
      fired = rd_rsp_valid && rd_rsp_ready;
      if (fired) begin
        burst_addr = burst_addr + 32'd4;
        burst_left--;
      end
      if (rd_req_valid && rd_req_ready) begin
        n_req++;
        req_log.push_back(int'(rd_req_beats));
        chk("R7 burst size in range", 32'((rd_req_beats >= 1) && (int'(rd_req_beats) <= MAX_BURST)), 32'd1);
        chk("R7 burst within 4KB page", 32'((int'(rd_req_addr[11:0]) + 4 * int'(rd_req_beats)) <= 4096), 32'd1);
        chk("R4 read address in order", rd_req_addr, exp_next_addr);
        exp_next_addr = rd_req_addr + 32'(4 * int'(rd_req_beats));
        burst_addr = rd_req_addr;
        burst_left = int'(rd_req_beats);
      end
    end
  end

  // stream sink and monitor
  initial begin
    m_tready = 1'b0;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0:       m_tready = 1'b1;
        1:       m_tready = cyc[0];
        default: m_tready = 1'b0;
      endcase
      #1;
      if (m_tvalid && m_tready) begin
        beats_seen++;
        if (m_tlast) lasts_seen++;
        if (exp_q.size() == 0) begin
          chk("R4 unexpected stream beat", {27'd0, m_tkeep, m_tlast}, 32'hFFFF);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk("R4 data order", m_tdata, e.data);
          chk("R5 tkeep", {28'd0, m_tkeep}, {28'd0, e.keep});
          chk("R4 tlast", {31'd0, m_tlast}, {31'd0, e.last});
        end
      end
    end
  end

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int b0, l0, q0;
    cfg_wr_en = 1'b0; cfg_wr_idx = '0; cfg_wr_data = '0; cfg_rd_idx = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cfg_read(2'd1, r); chk("R1 status after reset", r, 32'h1);
    cfg_read(2'd3, r); chk("R1 length after reset", r, 32'h0);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 no request", {31'd0, rd_req_valid}, 32'd0);
    chk("R1 no stream", {31'd0, m_tvalid}, 32'd0);

    // R2 R4 R7 R9 R10: 256-byte transfer
    rdy_mode = 0;
    cfg_write(2'd0, 32'h1);
    b0 = beats_seen; l0 = lasts_seen;
    start_xfer(32'h1000, 32'd256, 256);
    wait_idle();
    chk("R4 256 bytes give 64 beats", 32'(beats_seen - b0), 32'd64);
    chk("R4 one tlast", 32'(lasts_seen - l0), 32'd1);
    chk("R7 four bursts of 16", 32'(req_log.size()), 32'd4);
    foreach (req_log[i]) chk("R7 burst capped at 16", 32'(req_log[i]), 32'd16);
    cfg_read(2'd1, r); chk("R9 done and idle", r, 32'h3);
    chk("R10 irq from done", {31'd0, irq}, 32'd1);
    cfg_write(2'd1, 32'h0);
    cfg_read(2'd1, r); chk("R9 zero write keeps flag", r, 32'h3);
    cfg_write(2'd1, 32'h2);
    cfg_read(2'd1, r); chk("R9 W1C clears done", r, 32'h1);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R5 R12 partial last beats under backpressure
    rdy_mode = 1;
    for (int k = 13; k <= 16; k++) begin
      b0 = beats_seen;
      start_xfer(32'h2004, 32'(k), k);
      wait_idle();
      chk("R12 no beat lost under backpressure", 32'(beats_seen - b0), 32'd4);
      chk("R12 scoreboard drained", 32'(exp_q.size()), 32'd0);
    end

    // R7 page boundary split
    rdy_mode = 0;
    start_xfer(32'h0FF8, 32'd64, 64);
    wait_idle();
    chk("R7 split count", 32'(req_log.size()), 32'd2);
    if (req_log.size() == 2) begin
      chk("R7 first burst to page end", 32'(req_log[0]), 32'd2);
      chk("R7 second burst remainder", 32'(req_log[1]), 32'd14);
    end

    // R2 R3 length truncation and zero length
    q0 = n_req;
    cfg_write(2'd2, 32'h3000);
    cfg_write(2'd3, 32'h4000);
    repeat (10) @(negedge clk);
    chk("R3 truncated to zero starts nothing", 32'(n_req - q0), 32'd0);
    cfg_read(2'd3, r); chk("R3 stored length masked", r, 32'h0);
    cfg_write(2'd3, 32'h0);
    repeat (10) @(negedge clk);
    cfg_read(2'd1, r); chk("R2 zero length stays idle", r, 32'h3 & 32'h1 | (r & 32'h2));
    chk("R2 zero length no request", 32'(n_req - q0), 32'd0);
    b0 = beats_seen;
    start_xfer(32'h3000, 32'h4008, 8);
    wait_idle();
    chk("R3 0x4008 moves 8 bytes", 32'(beats_seen - b0), 32'd2);
    cfg_write(2'd1, 32'h2);

    // R6 misaligned start
    cfg_write(2'd0, 32'h2);
    q0 = n_req; b0 = beats_seen;
    cfg_write(2'd2, 32'h3002);
    cfg_write(2'd3, 32'd16);
    repeat (10) @(negedge clk);
    cfg_read(2'd1, r); chk("R6 error flag, idle", r, 32'h5);
    chk("R6 no request", 32'(n_req - q0), 32'd0);
    chk("R6 no beats", 32'(beats_seen - b0), 32'd0);
    chk("R10 irq from error", {31'd0, irq}, 32'd1);
    cfg_write(2'd1, 32'h4);
    cfg_read(2'd1, r); chk("R9 W1C clears error", r, 32'h1);
    chk("R10 irq low after clear", {31'd0, irq}, 32'd0);

    // R8 length write while busy
    rdy_mode = 2;
    b0 = beats_seen; l0 = lasts_seen;
    start_xfer(32'h5000, 32'd32, 32);
    repeat (20) @(negedge clk);
    cfg_write(2'd3, 32'd8);
    cfg_read(2'd3, r); chk("R8 stored length unchanged", r, 32'd32);
    rdy_mode = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 beats of original transfer only", 32'(beats_seen - b0), 32'd8);
    chk("R8 single tlast", 32'(lasts_seen - l0), 32'd1);
    cfg_write(2'd1, 32'h2);

    // R11 soft reset mid-transfer
    rdy_mode = 1;
    cfg_write(2'd0, 32'h1);
    b0 = beats_seen; l0 = lasts_seen;
    start_xfer(32'h6000, 32'd256, 256);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (beats_seen - b0 >= 10) break;
    end
    cfg_write(2'd0, 32'h4);
    wait_idle();
    repeat (5) @(negedge clk);
    exp_q.delete();
    chk("R11 no tlast after abort", 32'(lasts_seen - l0), 32'd0);
    chk("R11 transfer truncated", 32'((beats_seen - b0) < 64), 32'd1);
    cfg_read(2'd1, r); chk("R11 no completion, idle", r, 32'h1);
    cfg_read(2'd0, r); chk("R11 enables cleared", r, 32'h0);
    cfg_read(2'd2, r); chk("R11 source cleared", r, 32'h0);
    chk("R11 outstanding burst drained", 32'(burst_left), 32'd0);
    b0 = beats_seen;
    start_xfer(32'h7000, 32'd20, 20);
    wait_idle();
    chk("R11 restart after soft reset", 32'(beats_seen - b0), 32'd5);
    cfg_read(2'd1, r); chk("R9 done after restart", r, 32'h3);
    chk("R10 irq masked by cleared enable", {31'd0, irq}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule